// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the command side of a serial-flash-style byte memory that answers an SPI master. It runs on a fast system clock and takes SCK, SI and the active-low select as already-synchronised inputs. It finds the SCK edges, assembles bytes MSB first and decodes the first byte of every select window as an opcode. It then steps through address, dummy and data phases. The memory array is outside the block and is reached through a synchronous byte port with a read latency of one cycle.

Other blocks own the status register, the write-enable latch, the write-protection decision, the sleep state and the hold pin. This engine sends them one-cycle request pulses (set latch, clear latch, status write, sleep). It takes back the latch state, a per-address write permit, the status byte and a hold level. Serial output is given as a data bit plus an output enable, so that the pad can go high-impedance.

Top module: `spimem_engine`

## Requirements
- R1: SCK may idle low or idle high. SI is captured on each rising SCK edge and SO moves on each falling SCK edge, most significant bit first. Each SCK level lasts at least 3 clk cycles.
- R2: Opcode 03h is followed by three address bytes. Only the low AW bits of the 24-bit address are kept. The stored byte at that address is shifted out starting at the first falling edge after the last address bit.
- R3: Opcode 0Bh works like 03h, but one extra byte of 8 clocks is skipped after the address. SO stays disabled during that byte.
- R4: While the select stays low, each further 8 clocks of a read or write moves to the next address. The address after 2^AW-1 is 0.
- R5: Opcode 02h with three address bytes writes each complete data byte through a one-cycle mem_we pulse. The pulse is issued only when wel_i was high.
- R6: Bits of a data byte that is not complete when the select rises are discarded and nothing is written for them.
- R7: A data byte whose address has wr_permit_i low is dropped, and the address still advances.
- R8: Opcode 9Fh returns the bytes AEh, 83h and 09h in that order. SO is disabled after the third byte.
- R9: Opcode 05h returns sr_rdata_i, repeated for every byte until the select rises. Opcode 01h passes the next byte to sr_wdata_o with a sr_we_o pulse, only when wel_i is high.
- R10: Opcode 06h gives one wel_set_o pulse and opcode 04h gives one wel_clr_o pulse.
- R11: Opcode B9h gives one sleep_o pulse after the select rises, and none while it is still low.
- R12: Any other opcode makes the engine ignore SCK and SI and keep SO disabled until the select rises. The next command then works normally.
- R13: spi_so_oe is low out of reset, while the select is high, and during opcode, address and dummy bytes.
- R14: While hold_i is high, SCK edges have no effect and spi_so_oe is low. A transfer resumes bit-exact once hold_i falls at the same SCK level as when it rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, synchronised |
| spi_csn | input | 1 | Active-low select, synchronised |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the SO pad |
| hold_i | input | 1 | Pause request from the hold block |
| mem_addr | output | AW | Array address |
| mem_rd | output | 1 | Read strobe, data one cycle later |
| mem_rdata | input | 8 | Array read data |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Array write data |
| wel_i | input | 1 | Write-enable latch state |
| wr_permit_i | input | 1 | Protection permit for mem_addr |
| wel_set_o | output | 1 | Latch set request |
| wel_clr_o | output | 1 | Latch clear request |
| sr_rdata_i | input | 8 | Status byte to return |
| sr_we_o | output | 1 | Status write request |
| sr_wdata_o | output | 8 | Status write data |
| sleep_o | output | 1 | Sleep entry request |

## Verification
The streaming function is tried with reads and writes that start a few bytes below the top address, so that a wrong wrap shows as data from the wrong location. Both SCK idle levels are used, which separates an edge-based engine from one that relies on the idle level. A write that ends with a partial byte, and a write that crosses a permit boundary, show whether bytes are committed at the byte edge and qualified one byte at a time. Fast read against plain read, and a hold inserted in the middle of a byte, show whether the bit count is kept exactly across pauses and dummy clocks.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [7:0] OP_RD        = 8'h03;
    localparam logic [7:0] OP_WR        = 8'h02;
    localparam logic [7:0] OP_RD_FAST   = 8'h0B;
    localparam logic [7:0] OP_IDENT     = 8'h9F;
    localparam logic [7:0] OP_SLEEP     = 8'hB9;

    localparam logic [7:0] IDENT_B0 = 8'hAE;
    localparam logic [7:0] IDENT_B1 = 8'h83;
    localparam logic [7:0] IDENT_B2 = 8'h09;

    typedef enum logic [3:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_RDATA,
        PH_WDATA,
        PH_SROUT,
        PH_SRIN,
        PH_IDOUT,
        PH_DONE,
        PH_IGNORE
    } phase_e;

endpackage

// File: rtl/spimem_edge.sv
module spimem_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic csn,
    input  logic hold,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q, csn_q;
    logic active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck;
            csn_q <= csn;
        end
    end

    assign active   = !csn && !hold;
    assign sck_rise = active && sck && !sck_q;
    assign sck_fall = active && !sck && sck_q;
    assign cs_rise  = csn && !csn_q;
endmodule

// File: rtl/spimem_rx.sv
module spimem_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csn,
    input  logic       rise,
    input  logic       si,
    output logic       byte_vld,
    output logic [7:0] byte_val
);
    logic [2:0] cnt_d, cnt_q;
    logic [6:0] sh_d, sh_q;

    always_comb begin
        cnt_d = cnt_q;
        sh_d  = sh_q;
        if (csn) begin
            cnt_d = 3'd0;
        end else if (rise) begin
            cnt_d = cnt_q + 3'd1;
            sh_d  = {sh_q[5:0], si};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= 3'd0;
            sh_q  <= 7'd0;
        end else begin
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
        end
    end

    assign byte_vld = rise && (cnt_q == 3'd7);
    assign byte_val = {sh_q, si};
endmodule

// File: rtl/spimem_tx.sv
module spimem_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       fall,
    output logic       so
);
    logic [7:0] sh_d, sh_q;
    logic       so_d, so_q;

    always_comb begin
        sh_d = sh_q;
        so_d = so_q;
        if (load) begin
            sh_d = load_val;
        end else if (fall) begin
            so_d = sh_q[7];
            sh_d = {sh_q[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= 8'd0;
            so_q <= 1'b0;
        end else begin
            sh_q <= sh_d;
            so_q <= so_d;
        end
    end

    assign so = so_q;
endmodule

// File: rtl/spimem_engine.sv
module spimem_engine #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_csn,
    input  logic          spi_si,
    output logic          spi_so,
    output logic          spi_so_oe,
    input  logic          hold_i,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    input  logic [7:0]    mem_rdata,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic          wel_i,
    input  logic          wr_permit_i,
    output logic          wel_set_o,
    output logic          wel_clr_o,
    input  logic [7:0]    sr_rdata_i,
    output logic          sr_we_o,
    output logic [7:0]    sr_wdata_o,
    output logic          sleep_o
);
    import spimem_pkg::*;

    localparam logic [AW-1:0] ADDR_STEP = AW'(1);

    typedef struct packed {
        phase_e        ph;
        logic [15:0]   ab;
        logic [1:0]    idx;
        logic          fast;
        logic          wr;
        logic [AW-1:0] addr;
        logic          rd;
        logic          rd2;
        logic          we;
        logic [7:0]    wd;
        logic          inc;
        logic          oe;
        logic          sleep_pend;
        logic          sleep;
        logic          wset;
        logic          wclr;
        logic          srwe;
        logic [7:0]    srwd;
    } st_t;

    st_t        st_d, st_q;
    logic       sck_rise, sck_fall, cs_rise;
    logic       byte_vld;
    logic [7:0] byte_val;
    logic       tx_load;
    logic [7:0] tx_val;

    spimem_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .csn      (spi_csn),
        .hold     (hold_i),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    spimem_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn      (spi_csn),
        .rise     (sck_rise),
        .si       (spi_si),
        .byte_vld (byte_vld),
        .byte_val (byte_val)
    );

    spimem_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (tx_val),
        .fall     (sck_fall),
        .so       (spi_so)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rd    = 1'b0;
        st_d.we    = 1'b0;
        st_d.inc   = 1'b0;
        st_d.sleep = 1'b0;
        st_d.wset  = 1'b0;
        st_d.wclr  = 1'b0;
        st_d.srwe  = 1'b0;
        st_d.rd2   = st_q.rd;
        tx_load    = 1'b0;
        tx_val     = 8'h00;

        // array data arrives one cycle after the strobe: load it, step on
        if (st_q.rd2) begin
            tx_load   = 1'b1;
            tx_val    = mem_rdata;
            st_d.addr = st_q.addr + ADDR_STEP;
        end
        if (st_q.inc) begin
            st_d.addr = st_q.addr + ADDR_STEP;
        end

        if (spi_csn) begin
            st_d.ph         = PH_CMD;
            st_d.idx        = 2'd0;
            st_d.oe         = 1'b0;
            st_d.fast       = 1'b0;
            st_d.wr         = 1'b0;
            st_d.sleep      = cs_rise && st_q.sleep_pend;
            st_d.sleep_pend = 1'b0;
        end else begin
            if (sck_fall && (st_q.ph inside {PH_RDATA, PH_SROUT, PH_IDOUT})) begin
                st_d.oe = 1'b1;
            end
            if (byte_vld) begin
                unique case (st_q.ph)
                    PH_CMD: begin
                        unique case (byte_val)
                            OP_LATCH_SET: begin st_d.wset = 1'b1; st_d.ph = PH_DONE; end
                            OP_LATCH_CLR: begin st_d.wclr = 1'b1; st_d.ph = PH_DONE; end
                            OP_STAT_RD: begin
                                tx_load = 1'b1;
                                tx_val  = sr_rdata_i;
                                st_d.ph = PH_SROUT;
                            end
                            OP_STAT_WR: st_d.ph = PH_SRIN;
                            OP_RD:      st_d.ph = PH_ADDR;
                            OP_RD_FAST: begin st_d.ph = PH_ADDR; st_d.fast = 1'b1; end
                            OP_WR:      begin st_d.ph = PH_ADDR; st_d.wr = 1'b1; end
                            OP_IDENT: begin
                                tx_load  = 1'b1;
                                tx_val   = IDENT_B0;
                                st_d.idx = 2'd1;
                                st_d.ph  = PH_IDOUT;
                            end
                            OP_SLEEP: begin st_d.sleep_pend = 1'b1; st_d.ph = PH_DONE; end
                            default:  st_d.ph = PH_IGNORE;
                        endcase
                    end
                    PH_ADDR: begin
                        st_d.ab  = {st_q.ab[7:0], byte_val};
                        st_d.idx = st_q.idx + 2'd1;
                        if (st_q.idx == 2'd2) begin
                            st_d.addr = AW'({st_q.ab, byte_val});
                            st_d.idx  = 2'd0;
                            if (st_q.wr) begin
                                st_d.ph = PH_WDATA;
                            end else if (st_q.fast) begin
                                st_d.ph = PH_DUMMY;
                            end else begin
                                st_d.ph = PH_RDATA;
                                st_d.rd = 1'b1;
                            end
                        end
                    end
                    PH_DUMMY: begin
                        st_d.ph = PH_RDATA;
                        st_d.rd = 1'b1;
                    end
                    PH_RDATA: st_d.rd = 1'b1;
                    PH_WDATA: begin
                        st_d.we  = wel_i && wr_permit_i;
                        st_d.wd  = byte_val;
                        st_d.inc = 1'b1;
                    end
                    PH_SROUT: begin
                        tx_load = 1'b1;
                        tx_val  = sr_rdata_i;
                    end
                    PH_SRIN: begin
                        st_d.srwe = wel_i;
                        st_d.srwd = byte_val;
                        st_d.ph   = PH_DONE;
                    end
                    PH_IDOUT: begin
                        st_d.idx = st_q.idx + 2'd1;
                        if (st_q.idx == 2'd1) begin
                            tx_load = 1'b1;
                            tx_val  = IDENT_B1;
                        end else if (st_q.idx == 2'd2) begin
                            tx_load = 1'b1;
                            tx_val  = IDENT_B2;
                        end else begin
                            st_d.ph = PH_DONE;
                        end
                    end
                    default: ;
                endcase
            end
            if (st_d.ph inside {PH_DONE, PH_IGNORE}) begin
                st_d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_so_oe  = st_q.oe && !hold_i;
    assign mem_addr   = st_q.addr;
    assign mem_rd     = st_q.rd;
    assign mem_we     = st_q.we;
    assign mem_wdata  = st_q.wd;
    assign wel_set_o  = st_q.wset;
    assign wel_clr_o  = st_q.wclr;
    assign sr_we_o    = st_q.srwe;
    assign sr_wdata_o = st_q.srwd;
    assign sleep_o    = st_q.sleep;
endmodule

// File: rtl/spimem_chk.sv
module spimem_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_csn,
    input logic spi_so_oe,
    input logic mem_rd,
    input logic mem_we,
    input logic wel_i,
    input logic wr_permit_i,
    input logic wel_set_o,
    input logic wel_clr_o,
    input logic sr_we_o,
    input logic sleep_o
);
    a_r13_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_csn) |-> !spi_so_oe);

    a_r7_write_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(wel_i && wr_permit_i));

    a_r9_status_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we_o |-> $past(wel_i));

    a_r5_no_read_write_mix: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

    a_r10_latch_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(wel_set_o && wel_clr_o));

    a_r11_sleep_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> spi_csn);

    a_r11_sleep_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> !sleep_o);
endmodule

bind spimem_engine spimem_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_so_oe   (spi_so_oe),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .wel_i       (wel_i),
    .wr_permit_i (wr_permit_i),
    .wel_set_o   (wel_set_o),
    .wel_clr_o   (wel_clr_o),
    .sr_we_o     (sr_we_o),
    .sleep_o     (sleep_o)
);

// File: tb/tb_spimem_engine.sv
module tb_spimem_engine;
    localparam int AW    = 4;
    localparam int DEPTH = 16;
    localparam int H     = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, sck, csn, si, hold;
    logic so, so_oe;
    logic [AW-1:0] mem_addr;
    logic mem_rd, mem_we;
    logic [7:0] mem_rdata, mem_wdata;
    logic wel, wr_permit, wel_set, wel_clr, sr_we, sleep;
    logic [7:0] sr_wdata;
    logic [7:0] sr_rdata = 8'h8C;
    logic [4:0] prot_lim;

    logic [7:0] mem [DEPTH];
    logic [7:0] expm [DEPTH];
    int n_chk = 0, n_fail = 0;
    int n_wset = 0, n_wclr = 0, n_we = 0, n_sleep = 0, n_srwe = 0;
    logic [7:0] last_srwd;
    bit mode3 = 1'b0;
    bit exp_wel = 1'b0;
    logic csn_seen = 1'b1;

    spimem_engine #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .hold_i(hold),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata),
        .wel_i(wel), .wr_permit_i(wr_permit),
        .wel_set_o(wel_set), .wel_clr_o(wel_clr),
        .sr_rdata_i(sr_rdata), .sr_we_o(sr_we), .sr_wdata_o(sr_wdata),
        .sleep_o(sleep)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 29 + 7);
    endfunction

    assign wr_permit = ({1'b0, mem_addr} < prot_lim);

    // surrounding blocks: array, latch, request counters
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
            wel <= 1'b0;
        end else begin
            if (mem_we) begin mem[mem_addr] <= mem_wdata; n_we++; end
            if (mem_rd) mem_rdata <= mem[mem_addr];
            if (wel_set) begin wel <= 1'b1; n_wset++; end
            else if (wel_clr) begin wel <= 1'b0; n_wclr++; end
            if (sleep) n_sleep++;
            if (sr_we) begin n_srwe++; last_srwd <= sr_wdata; end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock model of the output enable: never on once the select was high
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (csn_seen) chk("R13 oe while deselected", int'(so_oe), 0);
            csn_seen = csn;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low(input bit m3);
        mode3 = m3;
        @(negedge clk);
        sck = m3;
        waitc(H);
        csn = 1'b0;
        waitc(H);
    endtask

    task automatic cs_high();
        if (!mode3) begin sck = 1'b0; waitc(H); end
        csn = 1'b1;
        waitc(3 * H);
    endtask

    task automatic xbit(input logic b, output logic sb, output logic ob);
        sck = 1'b0;
        si  = b;
        waitc(H);
        sb  = so;
        ob  = so_oe;
        sck = 1'b1;
        waitc(H);
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r,
                         output logic oe_any, output logic oe_all);
        logic sb, ob;
        r = 8'h00; oe_any = 1'b0; oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xbit(t[i], sb, ob);
            r[i] = sb;
            oe_any |= ob;
            oe_all &= ob;
        end
    endtask

    task automatic send_addr(input int a, input string req);
        logic [7:0] r; logic oa, ol, any;
        any = 1'b0;
        xbyte(8'hA5, r, oa, ol); any |= oa;
        xbyte(8'h3C, r, oa, ol); any |= oa;
        xbyte({4'hC, 4'(a)}, r, oa, ol); any |= oa;
        chk({req, " R13 oe during address"}, int'(any), 0);
    endtask

    task automatic do_read(input bit m3, input bit fast, input int a, input int n, input string req);
        logic [7:0] r; logic oa, ol;
        cs_low(m3);
        xbyte(fast ? 8'h0B : 8'h03, r, oa, ol);
        chk({req, " R13 oe during opcode"}, int'(oa), 0);
        send_addr(a, req);
        if (fast) begin
            xbyte(8'h00, r, oa, ol);
            chk({req, " R3 oe during dummy"}, int'(oa), 0);
        end
        for (int k = 0; k < n; k++) begin
            xbyte(8'hFF, r, oa, ol);
            chk({req, " data"}, int'(r), int'(expm[(a + k) % DEPTH]));
            chk({req, " oe during data"}, int'(ol), 1);
        end
        cs_high();
    endtask

    task automatic do_write(input int a, input logic [7:0] d[$], input int partial, input string req);
        logic [7:0] r; logic oa, ol, sb, ob;
        cs_low(1'b0);
        xbyte(8'h02, r, oa, ol);
        send_addr(a, req);
        foreach (d[k]) begin
            xbyte(d[k], r, oa, ol);
            if (exp_wel && (((a + k) % DEPTH) < int'(prot_lim))) expm[(a + k) % DEPTH] = d[k];
        end
        for (int k = 0; k < partial; k++) xbit(1'b0, sb, ob);
        cs_high();
        for (int i = 0; i < DEPTH; i++) chk({req, " array"}, int'(mem[i]), int'(expm[i]));
    endtask

    task automatic one_op(input logic [7:0] op);
        logic [7:0] r; logic oa, ol;
        cs_low(1'b0);
        xbyte(op, r, oa, ol);
        cs_high();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r, r2; logic oa, ol, sb, ob, hoe;
        int base;
        rst_n = 1'b0; csn = 1'b1; sck = 1'b0; si = 1'b0; hold = 1'b0; prot_lim = 5'd16;
        for (int i = 0; i < DEPTH; i++) expm[i] = init_val(i);
        waitc(5);
        rst_n = 1'b1;
        waitc(2);
        chk("R13 reset oe", int'(so_oe), 0);
        chk("R5 reset we", int'(mem_we), 0);

        // R10 latch set
        one_op(8'h06); exp_wel = 1'b1;
        chk("R10 set pulses", n_wset, 1);

        // R5 R4 R6: wrapped write ending with a partial byte
        do_write(14, '{8'h11, 8'h22, 8'h33, 8'h44}, 5, "R5 R4 R6 wrap write");
        chk("R6 write count", n_we, 4);

        // R2 R4 R1: idle-high read across the top
        do_read(1'b1, 1'b0, 13, 5, "R2 R4 R1 read mode3");
        // R3: fast read, idle low
        do_read(1'b0, 1'b1, 3, 3, "R3 fast read");

        // R7: permit boundary at 8
        prot_lim = 5'd8;
        base = n_we;
        do_write(6, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 0, "R7 protected write");
        chk("R7 writes issued", n_we - base, 2);
        prot_lim = 5'd16;

        // R10 clear, then R5 write without the latch
        one_op(8'h04); exp_wel = 1'b0;
        chk("R10 clear pulses", n_wclr, 1);
        do_write(0, '{8'h5E}, 0, "R5 no latch write");

        // R8 identity
        cs_low(1'b0);
        xbyte(8'h9F, r, oa, ol);
        xbyte(8'h00, r, oa, ol); chk("R8 id byte0", int'(r), 'hAE);
        xbyte(8'h00, r, oa, ol); chk("R8 id byte1", int'(r), 'h83);
        xbyte(8'h00, r, oa, ol); chk("R8 id byte2", int'(r), 'h09);
        chk("R8 oe on id", int'(ol), 1);
        xbyte(8'h00, r, oa, ol); chk("R8 oe after id", int'(oa), 0);
        cs_high();

        // R9 status read in idle-high mode (R1)
        cs_low(1'b1);
        xbyte(8'h05, r, oa, ol);
        xbyte(8'h00, r, oa, ol); chk("R9 R1 status 1", int'(r), 'h8C);
        xbyte(8'h00, r, oa, ol); chk("R9 status 2", int'(r), 'h8C);
        chk("R9 status oe", int'(ol), 1);
        cs_high();

        // R9 status write with and without latch
        one_op(8'h06);
        cs_low(1'b0);
        xbyte(8'h01, r, oa, ol);
        xbyte(8'h0C, r, oa, ol);
        cs_high();
        chk("R9 status write count", n_srwe, 1);
        chk("R9 status write data", int'(last_srwd), 'h0C);
        one_op(8'h04);
        cs_low(1'b0);
        xbyte(8'h01, r, oa, ol);
        xbyte(8'h80, r, oa, ol);
        cs_high();
        chk("R9 status write blocked", n_srwe, 1);

        // R11 sleep
        cs_low(1'b0);
        xbyte(8'hB9, r, oa, ol);
        waitc(4 * H);
        chk("R11 no sleep while selected", n_sleep, 0);
        cs_high();
        chk("R11 sleep after deselect", n_sleep, 1);

        // R12 unknown opcode, even with latch set, then recovery
        one_op(8'h06);
        base = n_we;
        cs_low(1'b0);
        xbyte(8'h55, r, oa, ol);
        xbyte(8'h02, r, oa, ol); chk("R12 oe after unknown 1", int'(oa), 0);
        xbyte(8'h00, r, oa, ol); chk("R12 oe after unknown 2", int'(oa), 0);
        xbyte(8'hFF, r, oa, ol); chk("R12 oe after unknown 3", int'(oa), 0);
        cs_high();
        chk("R12 no write", n_we - base, 0);
        do_read(1'b0, 1'b0, 9, 2, "R12 recovery read");

        // R14 hold in the middle of a byte
        cs_low(1'b0);
        xbyte(8'h03, r, oa, ol);
        send_addr(2, "R14");
        xbyte(8'hFF, r, oa, ol); chk("R14 before hold", int'(r), int'(expm[2]));
        r2 = 8'h00;
        for (int i = 7; i >= 4; i--) begin xbit(1'b1, sb, ob); r2[i] = sb; end
        hold = 1'b1;
        waitc(2);
        hoe = so_oe;
        for (int k = 0; k < 3; k++) begin
            sck = 1'b0; waitc(H); hoe |= so_oe;
            sck = 1'b1; waitc(H); hoe |= so_oe;
        end
        chk("R14 oe during hold", int'(hoe), 0);
        hold = 1'b0;
        waitc(H);
        for (int i = 3; i >= 0; i--) begin xbit(1'b1, sb, ob); r2[i] = sb; end
        chk("R14 byte across hold", int'(r2), int'(expm[3]));
        xbyte(8'hFF, r, oa, ol); chk("R14 after hold", int'(r), int'(expm[4]));
        cs_high();

        finish_run();
    end
endmodule